// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block turns a fan's tachometer signal into a speed reading. It does not count tach pulses over a fixed time. Instead it times the tach signal: a counter advances on a slow reference tick, but only while a measurement window is open. The window opens on a tach rising edge and closes on the rising edge that comes a selected number of tach periods later. The captured count is therefore proportional to the fan period, so a larger value means a slower fan.

The reference tick comes from a divider on the system clock. The default divider gives a tick period of about 12.8 us. The tach input is synchronized, and only its rising edges are used. A result is published with a one-cycle valid strobe on a fixed schedule. The schedule is a long interval by default, or a shorter one when fast mode is selected.

If no window finished during an interval, or the counter ran out of range, the published value is all ones. This marks a stalled or very slow fan. A fan driven straight from a DC rail is measured continuously, with windows back to back. A pulse-width-driven fan gets one fresh window per interval.

Top module: `fanTachTimer`

## Requirements
- R1: The reference tick occurs once every TICK_DIV clock cycles. The published count is the number of ticks seen while the window is open. For a tach period of P clocks over N periods, the count is N*P/TICK_DIV, within one tick.
- R2: The 2-bit `nSel` input sets the window length. The values 2'b00, 2'b01, 2'b10 and 2'b11 select 1, 2, 3 and 4 tach periods. Each window runs from one tach rising edge to the Nth rising edge after it.
- R3: The period counter stops at all ones and never wraps. A window that runs past the counter's range publishes all ones.
- R4: When no window completed since the last publication, the published value is all ones. This covers a tach input stuck at a constant level.
- R5: `countValid` pulses for exactly one cycle. The pulses come every SLOW_TICKS ticks when `fastMode` is 0, and every FAST_TICKS ticks when `fastMode` is 1.
- R6: When `dcDrive` is 1, windows run back to back across interval boundaries, and the latest completed one is published. When `dcDrive` is 0, each interval end abandons any open window, and a new window starts at the first rising edge after the boundary.
- R7: A change of `nSel` or `fastMode` abandons the open window and discards any result not yet published. The next window starts at the following rising edge, and a change of `fastMode` also restarts the interval timer.
- R8: After reset, `countValid` is 0 and `periodCount` is 0 until the first publication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tachIn | input | 1 | Raw tachometer signal, asynchronous |
| nSel | input | 2 | Number of tach periods per window, minus one |
| fastMode | input | 1 | Selects the short publication interval |
| dcDrive | input | 1 | Fan is rail-powered: measure continuously |
| periodCount | output | CNT_W | Published period count, all ones on stall |
| countValid | output | 1 | One-cycle strobe marking a new `periodCount` |

## Verification
The bench builds the block with a divider of 4 clocks per tick, an 8-bit counter, and intervals of 400 and 100 ticks. This makes a publication every 1600 or 400 clocks. With an 8-bit counter, saturation is reached with a tach period of about a thousand clocks, so the all-ones clamp can be told apart from a wrapped value. The short intervals let a single run cover both schedules, both drive modes, all four window lengths, a stalled fan and configuration changes made mid-window. A window longer than the fast interval separates continuous measurement from per-interval measurement.

// File: rtl/tachPkg.sv
package tachPkg;
  typedef struct packed {
    logic start;    // clear the counter, window opens
    logic run;      // window open: count on tick
    logic capture;  // window closes: hold the count
    logic publish;  // interval ended: emit a result
    logic discard;  // configuration changed: drop pending result
  } tachStrb_t;
endpackage

// File: rtl/tachFront.sv
module tachFront #(
  parameter int TICK_DIV = 1282
) (
  input  logic clk,
  input  logic rstN,
  input  logic tachIn,
  output logic rise,
  output logic tick
);
  localparam int DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

  logic [1:0]       syncQ;
  logic             prevQ;
  logic [DIV_W-1:0] divCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= 2'b00;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], tachIn};
      prevQ <= syncQ[1];
    end
  end

  assign rise = syncQ[1] & ~prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else                      divCnt <= divCnt + 1'b1;
  end

  assign tick = (divCnt == DIV_LAST);

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);
endmodule

// File: rtl/tachCtl.sv
module tachCtl
  import tachPkg::*;
#(
  parameter int SLOW_TICKS = 78000,
  parameter int FAST_TICKS = 19500
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rise,
  input  logic       tick,
  input  logic [1:0] nSel,
  input  logic       fastMode,
  input  logic       dcDrive,
  output tachStrb_t  strb
);
  localparam int INT_W = $clog2(SLOW_TICKS + 1);
  localparam logic [INT_W-1:0] SLOW_LAST = INT_W'(SLOW_TICKS - 1);
  localparam logic [INT_W-1:0] FAST_LAST = INT_W'(FAST_TICKS - 1);

  typedef enum logic [1:0] {ST_ARM, ST_MEAS, ST_HOLD} ctlState_t;

  ctlState_t        state;
  logic [1:0]       edgeCnt;
  logic [INT_W-1:0] intCnt;
  logic [1:0]       nSelQ;
  logic             fastQ;
  logic             fastChange, cfgChange, intervalEnd, lastEdge;
  logic [INT_W-1:0] intLast;

  assign intLast     = fastMode ? FAST_LAST : SLOW_LAST;
  assign fastChange  = (fastMode != fastQ);
  assign cfgChange   = fastChange || (nSel != nSelQ);
  assign intervalEnd = tick && (intCnt == intLast) && !fastChange;
  assign lastEdge    = (edgeCnt == nSel);

  always_comb begin
    strb         = '0;
    strb.discard = cfgChange;
    strb.publish = intervalEnd && !cfgChange;
    strb.run     = (state == ST_MEAS);
    strb.capture = !cfgChange && rise && (state == ST_MEAS) && lastEdge;
    strb.start   = !cfgChange && rise &&
                   ((state == ST_ARM) || (strb.capture && dcDrive));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nSelQ <= 2'b01;
      fastQ <= 1'b0;
    end else begin
      nSelQ <= nSel;
      fastQ <= fastMode;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            intCnt <= '0;
    else if (fastChange)  intCnt <= '0;
    else if (tick)        intCnt <= (intCnt == intLast) ? '0 : intCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_ARM;
      edgeCnt <= '0;
    end else if (cfgChange) begin
      state   <= ST_ARM;
      edgeCnt <= '0;
    end else if (intervalEnd && !dcDrive && state != ST_ARM) begin
      state   <= ST_ARM;
      edgeCnt <= '0;
    end else if (rise) begin
      unique case (state)
        ST_ARM: begin
          state   <= ST_MEAS;
          edgeCnt <= '0;
        end
        ST_MEAS: begin
          if (lastEdge) begin
            edgeCnt <= '0;
            state   <= dcDrive ? ST_MEAS : ST_HOLD;
          end else begin
            edgeCnt <= edgeCnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R5
  publish_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.publish |-> tick);
  // R2
  capture_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> rise);
endmodule

// File: rtl/tachDp.sv
module tachDp
  import tachPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  tachStrb_t        strb,
  output logic [CNT_W-1:0] result,
  output logic             valid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] held;
  logic             fresh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     cnt <= '0;
    else if (strb.start)                           cnt <= '0;
    else if (strb.run && tick && cnt != CNT_MAX)   cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      held  <= '0;
      fresh <= 1'b0;
    end else begin
      if (strb.capture) held <= cnt;
      if (strb.discard || strb.publish) fresh <= 1'b0;
      else if (strb.capture)            fresh <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result <= '0;
      valid  <= 1'b0;
    end else begin
      valid <= strb.publish;
      if (strb.publish)
        result <= strb.capture ? cnt : (fresh ? held : CNT_MAX);
    end
  end

  // R3
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_MAX && !strb.start) |=> cnt == CNT_MAX);
  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    valid |=> !valid);
endmodule

// File: rtl/fanTachTimer.sv
module fanTachTimer
  import tachPkg::*;
#(
  parameter int TICK_DIV   = 1282,
  parameter int CNT_W      = 16,
  parameter int SLOW_TICKS = 78000,
  parameter int FAST_TICKS = 19500
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tachIn,
  input  logic [1:0]       nSel,
  input  logic             fastMode,
  input  logic             dcDrive,
  output logic [CNT_W-1:0] periodCount,
  output logic             countValid
);
  logic      rise, tick;
  tachStrb_t strb;

  tachFront #(.TICK_DIV(TICK_DIV)) front_i (
    .clk(clk), .rstN(rstN), .tachIn(tachIn), .rise(rise), .tick(tick)
  );

  tachCtl #(.SLOW_TICKS(SLOW_TICKS), .FAST_TICKS(FAST_TICKS)) ctl_i (
    .clk(clk), .rstN(rstN), .rise(rise), .tick(tick), .nSel(nSel),
    .fastMode(fastMode), .dcDrive(dcDrive), .strb(strb)
  );

  tachDp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .tick(tick), .strb(strb),
    .result(periodCount), .valid(countValid)
  );
endmodule

// File: tb/fanTachTimer_tb_top.sv
module fanTachTimer_tb_top;
  localparam int TICK_DIV = 4;
  localparam int CNT_W    = 8;
  localparam int SLOW_T   = 400;
  localparam int FAST_T   = 100;
  localparam int ALL1     = 255;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tachIn = 1'b0;
  logic [1:0] nSel = 2'b01;
  logic fastMode = 1'b0;
  logic dcDrive = 1'b0;
  logic [CNT_W-1:0] periodCount;
  logic countValid;

  int tachPer = 0;
  int nChk = 0;
  int nErr = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fanTachTimer #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W),
                 .SLOW_TICKS(SLOW_T), .FAST_TICKS(FAST_T)) dut_i (
    .clk(clk), .rstN(rstN), .tachIn(tachIn), .nSel(nSel),
    .fastMode(fastMode), .dcDrive(dcDrive),
    .periodCount(periodCount), .countValid(countValid)
  );

  initial forever begin
    if (tachPer == 0) begin
      tachIn = 1'b0;
      @(negedge clk);
    end else begin
      tachIn = 1'b1;
      repeat (tachPer / 2) @(negedge clk);
      tachIn = 1'b0;
      repeat (tachPer - tachPer / 2) @(negedge clk);
    end
  end

  // {nSel, fastMode, dcDrive, tach period, expected count}
  localparam int NV = 6;
  localparam int VEC [NV][5] = '{
    '{1, 0, 0, 100,  50},
    '{0, 0, 0, 120,  30},
    '{2, 0, 1,  80,  60},
    '{3, 0, 0, 200, 200},
    '{1, 1, 0,  40,  20},
    '{3, 1, 1,  20,  20}
  };

  task automatic chk(input string tag, input int got, input int expv, input int tol);
    nChk++;
    if (got < expv - tol || got > expv + tol) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d (+/-%0d)", tag, got, expv, tol);
    end
  endtask

  task automatic waitValid();
    do @(negedge clk); while (countValid !== 1'b1);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    nChk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int t0;
    int v;
    int okCnt;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 valid in reset", countValid, 0, 0);
    chk("R8 count in reset", periodCount, 0, 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8 valid after reset", countValid, 0, 0);
    chk("R8 count after reset", periodCount, 0, 0);

    // R1 R2 R6: table of configurations
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      nSel = VEC[i][0][1:0];
      fastMode = VEC[i][1][0];
      dcDrive = VEC[i][2][0];
      tachPer = VEC[i][3];
      waitValid();
      waitValid();
      chk($sformatf("R1/R2 vec%0d first", i), periodCount, VEC[i][4], 1);
      waitValid();
      chk($sformatf("R1/R2 vec%0d second", i), periodCount, VEC[i][4], 1);
    end

    // R5: publication spacing, fast then slow
    @(negedge clk);
    fastMode = 1'b1;
    waitValid();
    t0 = cyc;
    waitValid();
    chk("R5 fast interval", cyc - t0, FAST_T * TICK_DIV, 0);
    @(negedge clk);
    chk("R5 valid one cycle", countValid, 0, 0);
    fastMode = 1'b0;
    waitValid();
    t0 = cyc;
    waitValid();
    chk("R5 slow interval", cyc - t0, SLOW_T * TICK_DIV, 0);

    // R4: stalled fan
    dcDrive = 1'b0;
    tachPer = 0;
    waitValid();
    waitValid();
    chk("R4 stall", periodCount, ALL1, 0);

    // R3: window beyond counter range (300 ticks) clamps, wrap would give 44
    nSel = 2'b00;
    dcDrive = 1'b1;
    tachPer = 1200;
    waitValid();
    waitValid();
    waitValid();
    chk("R3 saturate", periodCount, ALL1, 0);

    // R6: window of 150 ticks longer than the fast interval
    nSel = 2'b01;
    fastMode = 1'b1;
    dcDrive = 1'b0;
    tachPer = 300;
    waitValid();
    for (int k = 0; k < 3; k++) begin
      waitValid();
      chk("R6 per-interval window abandoned", periodCount, ALL1, 0);
    end
    dcDrive = 1'b1;
    waitValid();
    okCnt = 0;
    for (int k = 0; k < 4; k++) begin
      waitValid();
      v = periodCount;
      if (v != ALL1) begin
        chk("R6 continuous window value", v, 150, 1);
        okCnt++;
      end
    end
    chk("R6 continuous windows publish", okCnt > 0 ? 1 : 0, 1, 0);

    // R7: change of window length mid-measurement
    fastMode = 1'b0;
    nSel = 2'b00;
    tachPer = 100;
    waitValid();
    waitValid();
    chk("R7 before change", periodCount, 25, 1);
    repeat (430) @(negedge clk);
    nSel = 2'b11;
    waitValid();
    v = periodCount;
    chk("R7 no stale result", (v == ALL1 || (v >= 99 && v <= 101)) ? 1 : 0, 1, 0);
    waitValid();
    chk("R7 new length", periodCount, 100, 1);

    finishRun();
  end
endmodule